// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

A memory-mapped countdown timer for periodic ticks and single timed events. Software writes a start value into a load register, picks a tick source and a mode in a control register, and sets the enable bit. The count then drops by one on every strobe of the selected tick input. When the count passes below zero, the timer raises a sticky interrupt. In periodic mode it then restarts from the load value. In free-running mode it wraps to all ones.

Software schedules a single event the same way each time: it disables the timer, writes the new load value, and enables the timer again. A write of any data to the acknowledge register drops the pending interrupt. The tick strobes come from outside the block as single-cycle enables, and the counter width is a parameter.

Top module: `interval_timer`

## Requirements
- R1: After reset the load value, the count, the control register and irq_o are all zero.
- R2: A write to the load register (byte offset 0x0) stores the value and copies it into the counter in the same clock edge. Offset 0x0 reads back the load value and offset 0x4 reads back the live count.
- R3: The control register is at offset 0x8. Bit 7 enables counting, bit 6 set selects periodic mode, and bit 3 set selects the fast tick. All other control bits read as zero, and writing 0 to the control register stops the timer.
- R4: While the enable bit is 0, the count holds its value whatever the tick inputs do.
- R5: While enabled, each strobe of the selected tick decrements the count by one: tick_fast_i when bit 3 is 1, tick_slow_i when bit 3 is 0. Strobes on the other tick input have no effect.
- R6: In periodic mode, a tick that finds the count at 0 reloads the count from the load register.
- R7: In free-running mode (bit 6 = 0), a tick that finds the count at 0 sets the count to all ones.
- R8: A tick that finds the count at 0 sets irq_o from the next cycle. irq_o stays set through later underflows until it is acknowledged.
- R9: A write of any data to offset 0xC clears irq_o. If an underflow happens in the same cycle as that write, irq_o stays set.
- R10: The counter width is CNT_W bits. Load and count bits above CNT_W read as zero, and a 32-bit instance accepts loads up to 0xFFFFFFFF.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_slow_i | input | 1 | Slow tick strobe |
| tick_fast_i | input | 1 | Fast tick strobe |
| irq_o | output | 1 | Sticky underflow interrupt |

## Verification
The bench sweeps periodic load values from 1 to 12 and checks the count after every tick and the reload point. A design with an off-by-one in the underflow detection would fire one tick early or late, or would reload to a wrong value. Free-running wrap is checked on both a 32-bit and a 16-bit instance; a design that reloaded in this mode, or that leaked upper bits, would read back a wrong count. The bench also drives each tick source against the selected source, ticks while the timer is disabled, and issues an acknowledge in the same cycle as an underflow. Each of these exposes a design that counts the wrong strobe, drifts while stopped, or loses an interrupt to the race.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  localparam logic [1:0] IDX_LOAD  = 2'd0;
  localparam logic [1:0] IDX_VALUE = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;
  localparam logic [1:0] IDX_ACK   = 2'd3;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_PER  = 6;
  localparam int unsigned BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast_sel;
  } ctrl_t;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DW-1:0]    rdata_o,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] load_o,
  output logic             load_wr_o,
  output logic             ack_wr_o
);
  logic [1:0] idx;
  logic       unused_addr;
  ctrl_t      ctrl_q;
  logic [CNT_W-1:0] load_q;

  assign idx         = addr_i[3:2];
  assign unused_addr = ^addr_i[1:0];

  assign load_wr_o = wr_i && (idx == IDX_LOAD);
  assign ack_wr_o  = wr_i && (idx == IDX_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (load_wr_o) load_q <= wdata_i[CNT_W-1:0];
      if (wr_i && idx == IDX_CTRL) begin
        ctrl_q.en       <= wdata_i[BIT_EN];
        ctrl_q.periodic <= wdata_i[BIT_PER];
        ctrl_q.fast_sel <= wdata_i[BIT_FAST];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_LOAD:  rdata_o = DW'(load_q);
      IDX_VALUE: rdata_o = DW'(count_i);
      IDX_CTRL: begin
        rdata_o[BIT_EN]   = ctrl_q.en;
        rdata_o[BIT_PER]  = ctrl_q.periodic;
        rdata_o[BIT_FAST] = ctrl_q.fast_sel;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

  AST_CTRL_ZERO_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx == IDX_CTRL && wdata_i == '0) |=> !ctrl_o.en); // R3
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_wdata_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic tick;
  logic [CNT_W-1:0] cnt_q;

  assign tick        = ctrl_i.en && (ctrl_i.fast_sel ? tick_fast_i : tick_slow_i);
  assign underflow_o = tick && (cnt_q == '0) && !load_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_wr_i) cnt_q <= load_wdata_i;
    else if (tick) begin
      if (cnt_q == '0) cnt_q <= ctrl_i.periodic ? load_i : ALL_ONES;
      else             cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !load_wr_i) |=> $stable(count_o)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !load_wr_i && count_o != '0) |=> count_o == $past(count_o) - ONE); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && ctrl_i.periodic) |=> count_o == $past(load_i)); // R6
  AST_FREE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !ctrl_i.periodic) |=> count_o == ALL_ONES); // R7
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic underflow_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_q <= 1'b0;
    else if (underflow_i) irq_q <= 1'b1;
    else if (ack_i)       irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |=> irq_o); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o); // R8
  AST_IRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !underflow_i) |=> !irq_o); // R9
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [3:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          tick_slow_i,
  input  logic          tick_fast_i,
  output logic          irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             load_wr;
  logic             ack_wr;
  logic             underflow;

  initial begin
    AST_WIDTH_OK: assert (CNT_W == 16 || CNT_W == 32); // R10
  end

  itmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .count_i   (count),
    .rdata_o,
    .ctrl_o    (ctrl),
    .load_o    (load_val),
    .load_wr_o (load_wr),
    .ack_wr_o  (ack_wr)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni,
    .ctrl_i       (ctrl),
    .tick_slow_i, .tick_fast_i,
    .load_wr_i    (load_wr),
    .load_wdata_i (wdata_i[CNT_W-1:0]),
    .load_i       (load_val),
    .count_o      (count),
    .underflow_o  (underflow)
  );

  itmr_irq u_irq (
    .clk_i, .rst_ni,
    .underflow_i (underflow),
    .ack_i       (ack_wr),
    .irq_o
  );

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] == IDX_VALUE) |-> (rdata_o >> CNT_W) == '0); // R10
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we32 = 1'b0, we16 = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd32, rd16;
  logic t_slow = 1'b0, t_fast = 1'b0;
  logic irq32, irq16;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_timer #(.CNT_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(we32), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd32), .tick_slow_i(t_slow), .tick_fast_i(t_fast), .irq_o(irq32));

  interval_timer #(.CNT_W(16)) dut16_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(we16), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd16), .tick_slow_i(t_slow), .tick_fast_i(t_fast), .irq_o(irq16));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input bit w16, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we32 = !w16; we16 = w16;
    @(negedge clk);
    we32 = 1'b0; we16 = 1'b0;
  endtask

  task automatic rd(input bit w16, input logic [3:0] a, output logic [31:0] d);
    addr = a; #1;
    d = w16 ? rd16 : rd32;
  endtask

  task automatic tick(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_fast = fast; t_slow = !fast;
      @(negedge clk);
      t_fast = 1'b0; t_slow = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, 4'h0, v); chk("R1 load", v, 0);
    rd(0, 4'h4, v); chk("R1 value", v, 0);
    rd(0, 4'h8, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", 32'(irq32), 0);

    // R2 load copies into counter
    wr(0, 4'h0, 32'd5);
    rd(0, 4'h0, v); chk("R2 load", v, 5);
    rd(0, 4'h4, v); chk("R2 value", v, 5);

    // R3 control readback masks unused bits
    wr(0, 4'h8, 32'hFFFF_FF7F);
    rd(0, 4'h8, v); chk("R3 ctrl mask", v, 32'h48);
    // R4 disabled holds
    tick(1, 3); tick(0, 3);
    rd(0, 4'h4, v); chk("R4 hold", v, 5);

    // R5/R6/R8 periodic sweep on fast tick
    for (int l = 1; l <= 12; l++) begin
      wr(0, 4'h8, 32'h0);
      wr(0, 4'hC, 32'h0);
      wr(0, 4'h0, 32'(l));
      wr(0, 4'h8, 32'hC8);
      for (int n = 1; n <= l; n++) begin
        tick(1, 1);
        rd(0, 4'h4, v); chk("R5 step", v, 32'(l - n));
      end
      chk("R8 no early irq", 32'(irq32), 0);
      tick(1, 1);
      rd(0, 4'h4, v); chk("R6 reload", v, 32'(l));
      chk("R8 irq set", 32'(irq32), 1);
    end

    // R8 sticky across second underflow, R9 clear
    wr(0, 4'h0, 32'd1);
    tick(1, 2);
    chk("R8 sticky", 32'(irq32), 1);
    wr(0, 4'hC, 32'hDEAD_BEEF);
    chk("R9 clear", 32'(irq32), 0);

    // R9 underflow same cycle as ack: set wins
    wr(0, 4'h0, 32'd0);
    tick(1, 1);
    chk("R9 irq before race", 32'(irq32), 1);
    @(negedge clk);
    addr = 4'hC; wdata = 0; we32 = 1'b1; t_fast = 1'b1;
    @(negedge clk);
    we32 = 1'b0; t_fast = 1'b0;
    chk("R9 race keeps irq", 32'(irq32), 1);
    wr(0, 4'hC, 32'h1);
    chk("R9 ack after race", 32'(irq32), 0);

    // R5 slow select ignores fast
    wr(0, 4'h8, 32'h0);
    wr(0, 4'h0, 32'd4);
    wr(0, 4'h8, 32'hC0);
    tick(1, 2);
    rd(0, 4'h4, v); chk("R5 fast ignored", v, 4);
    tick(0, 3);
    rd(0, 4'h4, v); chk("R5 slow counts", v, 1);

    // R3 write 0 stops
    wr(0, 4'h8, 32'h0);
    tick(0, 2); tick(1, 2);
    rd(0, 4'h4, v); chk("R3 stopped", v, 1);

    // R7 free-running wrap
    wr(0, 4'hC, 32'h0);
    wr(0, 4'h0, 32'd2);
    wr(0, 4'h8, 32'h88);
    tick(1, 3);
    rd(0, 4'h4, v); chk("R7 wrap", v, 32'hFFFF_FFFF);
    chk("R8 irq free", 32'(irq32), 1);
    tick(1, 1);
    rd(0, 4'h4, v); chk("R7 after wrap", v, 32'hFFFF_FFFE);

    // R10 full 32-bit load, 16-bit truncation
    wr(0, 4'h8, 32'h0);
    wr(0, 4'h0, 32'hFFFF_FFFF);
    rd(0, 4'h0, v); chk("R10 max load", v, 32'hFFFF_FFFF);
    wr(1, 4'h0, 32'h1234_5678);
    rd(1, 4'h4, v); chk("R10 16b value", v, 32'h5678);
    rd(1, 4'h0, v); chk("R10 16b load", v, 32'h5678);
    wr(1, 4'h0, 32'h0);
    wr(1, 4'h8, 32'h88);
    tick(1, 1);
    rd(1, 4'h4, v); chk("R10 16b wrap", v, 32'h0000_FFFF);
    chk("R8 16b irq", 32'(irq16), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule